// File: doc/BRIEF.md
# RTC alarm and interrupt controller

This block is the interrupt side of a PC-style real-time clock. An external time counter supplies the current seconds, minutes, hour, day of month and month bytes, plus a one-cycle `sec_tick` pulse in the cycle where those bytes have just advanced. The block also receives a prescaled 32.768 kHz reference as a one-cycle `ref_tick` pulse. From these inputs it raises three kinds of event:

- a periodic event,
- an alarm event, when the programmed alarm time is reached,
- an update-ended event, once per second.

Each event sets a flag bit. An enable bit in the control register gates each flag onto one active-high interrupt request line.

Software reaches the registers through a byte-wide port addressed by a 4-bit register index. Reading the flag register returns the pending flags and clears them. Alarm fields can be made wildcards. Two optional alarm fields extend the alarm range from one day to one month or one year: a day-of-month field and a month field.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the registers read as follows: alarm registers (index 0..4) 0x00, rate register (index 5) 0x26, control register (index 6) 0x02, flag register (index 7) 0x00. After reset `irq` is low.
- R2: Register index 0 to 4 hold the second, minute, hour, day and month alarm bytes. Index 5 is the rate register: bits 6:4 are the reference select and bits 3:0 are the rate code. Index 6 is the control register. Writes to index 0..6 are stored and read back unchanged. Writes to index 7..15 have no effect, and index 8..15 read 0x00.
- R3: On a `sec_tick` cycle, the alarm flag AF (flag register bit 5) sets if every active alarm field equals the current time byte. With no `sec_tick`, AF does not set.
- R4: An alarm byte whose two top bits are both 1 (for example 0xFF or 0xC0) is a wildcard and matches any value of its field.
- R5: For the day alarm, only bits 5:0 are compared, against bits 5:0 of the current day. A day alarm or month alarm of 0x00 means the field is unused and always matches.
- R6: Every `sec_tick` sets the update flag UF (flag register bit 4).
- R7: The periodic flag PF (flag register bit 6) is generated only when the reference select is 3'b010 and the rate code r is in 1..15. PF then sets on every 2^(r-1)-th `ref_tick`, counted from the last write to the rate register. Rate code 0, or any other select value, never sets PF.
- R8: Control bits 6, 5 and 4 are the enables for PF, AF and UF. Flag register bit 7 (IRQF) and `irq` are 1 exactly when some flag is set together with its enable. A flag sets even while its enable is 0.
- R9: A read of index 7 returns the flags as they were before the read and then clears them, so `irq` falls in the next cycle. An event that arrives in the same cycle as the read stays set. Flags are never cleared by anything other than a read.
- R10: Control bit 2 (binary mode) and bit 1 (24-hour mode) are stored and read back. They do not change the alarm comparison, which compares raw bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse at 32768 Hz |
| sec_tick | input | 1 | One-cycle pulse when the time counter has advanced |
| cur_sec | input | 8 | Current seconds byte |
| cur_min | input | 8 | Current minutes byte |
| cur_hour | input | 8 | Current hours byte |
| cur_mday | input | 8 | Current day-of-month byte |
| cur_mon | input | 8 | Current month byte |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears flags at index 7) |
| reg_idx | input | 4 | Register index |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_idx`, combinational |
| irq | output | 1 | Active-high interrupt request |

## Verification
A wrong alarm comparison shows at the ports as an AF bit that is wrong on the first flag read after the offending `sec_tick`. A divider that is off by one shows as a PF bit that appears one reference tick early or late, counted from a rate write. A stuck or half-cleared flag shows as `irq`, or a set flag bit, in the cycle after a flag read. The read-clear race, where an event lands on the same edge as the clearing read, is visible on the very next read.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] IDX_ASEC  = 4'd0;
  localparam logic [3:0] IDX_AMIN  = 4'd1;
  localparam logic [3:0] IDX_AHOUR = 4'd2;
  localparam logic [3:0] IDX_ADAY  = 4'd3;
  localparam logic [3:0] IDX_AMON  = 4'd4;
  localparam logic [3:0] IDX_RATE  = 4'd5;
  localparam logic [3:0] IDX_CTRL  = 4'd6;
  localparam logic [3:0] IDX_FLAG  = 4'd7;
  localparam logic [7:0] RATE_RST  = 8'h26;
  localparam logic [7:0] CTRL_RST  = 8'h02;
  localparam logic [2:0] REF_SEL_ON = 3'b010;

  // A byte with both top bits set matches anything.
  function automatic logic is_wild(input logic [7:0] a);
    return a[7:6] == 2'b11;
  endfunction

  function automatic logic field_hit(input logic [7:0] a, input logic [7:0] c);
    return is_wild(a) || (a == c);
  endfunction

  // Day alarm: zero means unused; only the low six bits are compared.
  function automatic logic day_hit(input logic [7:0] a, input logic [5:0] c);
    return (a == 8'h00) || is_wild(a) || (a[5:0] == c);
  endfunction

  function automatic logic mon_hit(input logic [7:0] a, input logic [7:0] c);
    return (a == 8'h00) || is_wild(a) || (a == c);
  endfunction
endpackage

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_irq_pkg::*;
#(
  parameter bit HAS_DAY = 1'b1,
  parameter bit HAS_MON = 1'b1
) (
  input  logic [7:0] alarm_sec,
  input  logic [7:0] alarm_min,
  input  logic [7:0] alarm_hour,
  input  logic [7:0] alarm_day,
  input  logic [7:0] alarm_mon,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_mday,
  input  logic [7:0] cur_mon,
  output logic       hit
);
  logic hms_ok, day_ok, mon_ok;

  assign hms_ok = field_hit(alarm_sec, cur_sec) && field_hit(alarm_min, cur_min)
               && field_hit(alarm_hour, cur_hour);

  generate
    if (HAS_DAY) begin : g_day
      logic [1:0] unused_day_top;
      assign unused_day_top = cur_mday[7:6];
      assign day_ok = day_hit(alarm_day, cur_mday[5:0]);
    end else begin : g_noday
      logic [15:0] unused_day;
      assign unused_day = {alarm_day, cur_mday};
      assign day_ok = 1'b1;
    end
    if (HAS_MON && HAS_DAY) begin : g_mon
      assign mon_ok = mon_hit(alarm_mon, cur_mon);
    end else begin : g_nomon
      logic [15:0] unused_mon;
      assign unused_mon = {alarm_mon, cur_mon};
      assign mon_ok = 1'b1;
    end
  endgenerate

  assign hit = hms_ok && day_ok && mon_ok;
endmodule

// File: rtl/rtc_periodic_div.sv
module rtc_periodic_div #(
  parameter int CNT_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       restart,
  input  logic       run,
  input  logic [3:0] rate,
  output logic       per_evt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  // Low (rate-1) bits all ones marks every 2^(rate-1)-th reference tick.
  function automatic logic [CNT_W-1:0] mask_of(input logic [3:0] r);
    logic [CNT_W:0] p;
    p = {{CNT_W{1'b0}}, 1'b1} << (r - 4'd1);
    return p[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  assign mask    = mask_of(rate);
  assign per_evt = ref_tick && run && !restart && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt_q <= '0;
    else if (ref_tick)     cnt_q <= cnt_q + 1'b1;
  end

  // R7: no periodic event without a reference tick in the running mode
  a_r7_evt_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> (ref_tick && run));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] set_vec,
  input  logic       rd_clr,
  input  logic [2:0] en,
  output logic [2:0] flags,
  output logic       irqf
);
  always_ff @(posedge clk) begin
    if (!rst_n) flags <= 3'b000;
    else        flags <= (rd_clr ? 3'b000 : flags) | set_vec;
  end

  assign irqf = |(flags & en);

  // R9: a read with no coinciding event leaves no flag behind
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && set_vec == 3'b000) |=> (flags == 3'b000));

  // R9: without a read no flag is lost
  a_r9_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((flags & $past(flags)) == $past(flags)));

  // R9: an event on the same edge as the read survives
  a_r9_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != 3'b000) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter bit HAS_DAY = 1'b1,
  parameter bit HAS_MON = 1'b1,
  parameter int CNT_W   = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       sec_tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_mday,
  input  logic [7:0] cur_mon,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [3:0] reg_idx,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  logic [7:0] a_sec_q, a_min_q, a_hour_q, a_day_q, a_mon_q, rate_q, ctrl_q;
  logic       alarm_hit, per_evt, rate_wr, rd_clr, per_run, irqf;
  logic [2:0] flags, set_vec;

  assign rate_wr = reg_wr && (reg_idx == IDX_RATE);
  assign rd_clr  = reg_rd && (reg_idx == IDX_FLAG);
  assign per_run = (rate_q[6:4] == REF_SEL_ON) && (rate_q[3:0] != 4'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_sec_q <= 8'h00; a_min_q <= 8'h00; a_hour_q <= 8'h00;
      a_day_q <= 8'h00; a_mon_q <= 8'h00;
      rate_q  <= RATE_RST;
      ctrl_q  <= CTRL_RST;
    end else if (reg_wr) begin
      case (reg_idx)
        IDX_ASEC:  a_sec_q  <= reg_wdata;
        IDX_AMIN:  a_min_q  <= reg_wdata;
        IDX_AHOUR: a_hour_q <= reg_wdata;
        IDX_ADAY:  a_day_q  <= reg_wdata;
        IDX_AMON:  a_mon_q  <= reg_wdata;
        IDX_RATE:  rate_q   <= reg_wdata;
        IDX_CTRL:  ctrl_q   <= reg_wdata;
        default: ;
      endcase
    end
  end

  rtc_alarm_cmp #(.HAS_DAY(HAS_DAY), .HAS_MON(HAS_MON)) u_cmp (
    .alarm_sec(a_sec_q), .alarm_min(a_min_q), .alarm_hour(a_hour_q),
    .alarm_day(a_day_q), .alarm_mon(a_mon_q),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_mon(cur_mon), .hit(alarm_hit)
  );

  rtc_periodic_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .restart(rate_wr),
    .run(per_run), .rate(rate_q[3:0]), .per_evt(per_evt)
  );

  assign set_vec = {per_evt, sec_tick && alarm_hit, sec_tick};

  rtc_irq_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .rd_clr(rd_clr),
    .en(ctrl_q[6:4]), .flags(flags), .irqf(irqf)
  );

  assign irq = irqf;

  always_comb begin
    case (reg_idx)
      IDX_ASEC:  reg_rdata = a_sec_q;
      IDX_AMIN:  reg_rdata = a_min_q;
      IDX_AHOUR: reg_rdata = a_hour_q;
      IDX_ADAY:  reg_rdata = HAS_DAY ? a_day_q : 8'h00;
      IDX_AMON:  reg_rdata = (HAS_DAY && HAS_MON) ? a_mon_q : 8'h00;
      IDX_RATE:  reg_rdata = rate_q;
      IDX_CTRL:  reg_rdata = ctrl_q;
      IDX_FLAG:  reg_rdata = {irqf, flags, 4'h0};
      default:   reg_rdata = 8'h00;
    endcase
  end

  // R6: every second tick leaves the update flag set
  a_r6_update_flag: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> flags[0]);

  // R3: a matching second tick leaves the alarm flag set
  a_r3_alarm_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && alarm_hit) |=> flags[1]);

  // R8: with all enables clear the request line stays low
  a_r8_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6:4] == 3'b000) |-> !irq);
endmodule

// File: tb/tb_rtc_irq_ctrl.sv
`timescale 1ns/1ps
module tb_rtc_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, sec_tick = 1'b0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_mday = 0, cur_mon = 0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_idx = 4'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  rtc_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sec_tick(sec_tick),
    .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_mday(cur_mday), .cur_mon(cur_mon), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // alarm s,m,h,d,mo | current s,m,h,d,mo | expected AF
  localparam logic [87:0] VEC [10] = '{
    {8'h30,8'h15,8'h08,8'h00,8'h00, 8'h30,8'h15,8'h08,8'h12,8'h05, 8'h01},
    {8'h30,8'h15,8'h08,8'h00,8'h00, 8'h31,8'h15,8'h08,8'h12,8'h05, 8'h00},
    {8'hFF,8'h15,8'h08,8'h00,8'h00, 8'h47,8'h15,8'h08,8'h12,8'h05, 8'h01},
    {8'hC0,8'hFF,8'hD3,8'h00,8'h00, 8'h01,8'h22,8'h23,8'h01,8'h01, 8'h01},
    {8'h00,8'h00,8'h12,8'h12,8'h00, 8'h00,8'h00,8'h12,8'h12,8'h07, 8'h01},
    {8'h00,8'h00,8'h12,8'h12,8'h00, 8'h00,8'h00,8'h12,8'h13,8'h07, 8'h00},
    {8'h00,8'h00,8'h12,8'h52,8'h00, 8'h00,8'h00,8'h12,8'h12,8'h07, 8'h01},
    {8'h00,8'h00,8'h12,8'h12,8'h07, 8'h00,8'h00,8'h12,8'h12,8'h08, 8'h00},
    {8'h00,8'h00,8'h12,8'h12,8'h07, 8'h00,8'h00,8'h12,8'h12,8'h07, 8'h01},
    {8'h59,8'h59,8'h23,8'hFF,8'hFF, 8'h59,8'h59,8'h23,8'h31,8'h12, 8'h01}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_idx = idx; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_idx = idx;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  task automatic pulse_ref(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1 check("R1 irq", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 5; i++) begin
      rd(4'(i), rv); check("R1 alarm reg", rv, 8'h00);
    end
    rd(4'd5, rv); check("R1 rate reg", rv, 8'h26);
    rd(4'd6, rv); check("R1 ctrl reg", rv, 8'h02);
    rd(4'd7, rv); check("R1 flag reg", rv, 8'h00);

    // R2 / R10 storage and ignored indices
    wr(4'd1, 8'h5A); rd(4'd1, rv); check("R2 alarm min readback", rv, 8'h5A);
    wr(4'd6, 8'h06); rd(4'd6, rv); check("R10 ctrl mode bits", rv, 8'h06);
    wr(4'd7, 8'hF0); rd(4'd7, rv); check("R2 flag write ignored", rv, 8'h00);
    wr(4'd9, 8'h77); rd(4'd9, rv); check("R2 high index reads zero", rv, 8'h00);
    rd(4'd1, rv); check("R2 high write touched nothing", rv, 8'h5A);
    wr(4'd6, 8'h02);

    // R3 R4 R5 R6 R8 table walk, enables clear
    for (int i = 0; i < 10; i++) begin
      logic [87:0] v;
      v = VEC[i];
      wr(4'd0, v[87:80]); wr(4'd1, v[79:72]); wr(4'd2, v[71:64]);
      wr(4'd3, v[63:56]); wr(4'd4, v[55:48]);
      cur_sec = v[47:40]; cur_min = v[39:32]; cur_hour = v[31:24];
      cur_mday = v[23:16]; cur_mon = v[15:8];
      rd(4'd7, rv);
      pulse_sec();
      check("R8 irq low without enables", {7'd0, irq}, 8'h00);
      rd(4'd7, rv);
      check("R3 R4 R5 alarm flag", {7'd0, rv[5]}, v[7:0]);
      check("R6 update flag", {7'd0, rv[4]}, 8'h01);
      check("R8 no IRQF without enables", {7'd0, rv[7]}, 8'h00);
    end

    // R3 match present but no second tick; binary mode bit has no effect (R10)
    wr(4'd6, 8'h26);
    wr(4'd0, 8'h10); wr(4'd1, 8'h20); wr(4'd2, 8'h03); wr(4'd3, 8'h00); wr(4'd4, 8'h00);
    cur_sec = 8'h10; cur_min = 8'h20; cur_hour = 8'h03;
    rd(4'd7, rv);
    repeat (5) @(negedge clk);
    rd(4'd7, rv); check("R3 no flag without tick", rv, 8'h00);
    check("R8 irq low with no flag", {7'd0, irq}, 8'h00);
    pulse_sec();
    check("R8 irq with AF enabled", {7'd0, irq}, 8'h01);
    check("R10 binary bit ignored by compare", {7'd0, irq}, 8'h01);
    rd(4'd7, rv); check("R8 flags with AF enabled", rv, 8'hB0);
    check("R9 irq drops after read", {7'd0, irq}, 8'h00);
    rd(4'd7, rv); check("R9 flags cleared", rv, 8'h00);

    // R9 event coinciding with the clearing read is kept
    cur_sec = 8'h11;
    @(negedge clk); reg_rd = 1'b1; reg_idx = 4'd7; sec_tick = 1'b1;
    @(negedge clk); reg_rd = 1'b0; sec_tick = 1'b0;
    rd(4'd7, rv); check("R9 coincident event kept", rv, 8'h10);

    // R7 periodic divider, rate 3 -> every 4th tick
    wr(4'd6, 8'h42);
    wr(4'd5, 8'h23);
    rd(4'd7, rv);
    pulse_ref(3);
    rd(4'd7, rv); check("R7 no PF before 4th tick", rv, 8'h00);
    pulse_ref(1);
    check("R8 irq on PF", {7'd0, irq}, 8'h01);
    rd(4'd7, rv); check("R7 PF on 4th tick", rv, 8'hC0);
    pulse_ref(3);
    rd(4'd7, rv); check("R7 no PF mid period", rv, 8'h00);
    pulse_ref(1);
    rd(4'd7, rv); check("R7 PF next period", rv, 8'hC0);
    // rate 6 -> every 32nd tick
    wr(4'd5, 8'h26);
    pulse_ref(31);
    rd(4'd7, rv); check("R7 rate 6 before 32nd", rv, 8'h00);
    pulse_ref(1);
    rd(4'd7, rv); check("R7 rate 6 on 32nd", rv, 8'hC0);
    // rate 1 every tick
    wr(4'd5, 8'h21);
    pulse_ref(1);
    rd(4'd7, rv); check("R7 rate 1", rv, 8'hC0);
    // rate 0 never
    wr(4'd5, 8'h20);
    pulse_ref(40);
    rd(4'd7, rv); check("R7 rate 0 disabled", rv, 8'h00);
    // other reference select never
    wr(4'd5, 8'h01);
    pulse_ref(4);
    rd(4'd7, rv); check("R7 select off disabled", rv, 8'h00);
    check("R7 irq stays low", {7'd0, irq}, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule